// File: doc/BRIEF.md
# RS-485 Driver Direction Turnaround Controller

This block sits next to a UART transmitter and drives the direction-control pin of an external half-duplex RS-485 line transceiver. When the transmit shifter starts sending, the block drives the chosen direction pin high so the transceiver drives the line. When the stop bit of the final character has left the shifter and no more data is queued, the block counts a programmable number of bit periods. Only then does it drive the pin low, which hands the line back to the receiver.

The host programs the block through a small write port with two registers. The delay register holds the turnaround count in bit periods. The control register holds automatic-direction enable, the choice between the RTS and DTR outputs as the direction pin, the transmit-empty interrupt mode, and a self-clearing soft reset. The baud generator supplies one tick per bit time. The serializer supplies its busy level and a stop-bit-done pulse, and the FIFO supplies its empty and below-trigger flags. All of these are inputs to the block.

Top module: `rs485_dir_turnaround`

## Requirements
- R1: After `rst_n` is low, `dir_rts`, `dir_dtr` and `tx_empty_irq` are 0, the delay register is 0 and automatic direction is disabled.
- R2: With automatic direction enabled and the pin idle, `shift_busy` high at a clock edge drives the selected direction pin to 1 from that edge onward.
- R3: The countdown starts only at an edge where `stop_done` and `fifo_empty` are both high and `shift_busy` is low. A `stop_done` with `fifo_empty` low, or `fifo_empty` alone, leaves the pin at 1 for any number of baud ticks.
- R4: With delay value N (0 to 255), the pin stays 1 through the first N baud ticks after the countdown starts and falls to 0 at the edge that samples tick N+1. A delay of 0 therefore releases on the first tick.
- R5: `shift_busy` high while the countdown runs aborts it and holds the pin at 1. The next qualifying stop-bit-done reloads the full delay.
- R6: Control bit 1 selects the direction pin: 0 routes it to `dir_rts`, and 1 routes it to `dir_dtr`. The pin that is not selected stays 0.
- R7: With control bit 0 (automatic direction enable) at 0, both direction pins stay 0 whatever the shifter does.
- R8: With control bit 2 at 0, `tx_empty_irq` is registered one cycle after its inputs and equals `fifo_below_trig | fifo_empty`.
- R9: With control bit 2 at 1, `tx_empty_irq` equals `fifo_below_trig | (fifo_empty & !shift_busy)`, also one cycle late.
- R10: A control write with bit 3 set resets the block one cycle later. The pins go to 0, and the delay and control registers are cleared. The reset bit clears itself, so later writes take effect normally.
- R11: With `cfg_wr` high, `cfg_sel` 0 writes `cfg_wdata` into the delay register and `cfg_sel` 1 writes the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the delay register, 1 selects the control register |
| cfg_wdata | input | 8 | Write data |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| shift_busy | input | 1 | Transmit shifter is sending a character |
| stop_done | input | 1 | Pulse: a stop bit has just left the shifter |
| fifo_empty | input | 1 | Transmit FIFO is empty |
| fifo_below_trig | input | 1 | Transmit FIFO is below its trigger level |
| dir_rts | output | 1 | Direction on the RTS output (1 = drive, 0 = receive) |
| dir_dtr | output | 1 | Direction on the DTR output (1 = drive, 0 = receive) |
| tx_empty_irq | output | 1 | Transmit-empty interrupt level |

## Verification
The bench sweeps the delay value across 0 to 16 and 250 to 255. For each value it checks that the pin is still 1 after tick N and is 0 after tick N+1. An off-by-one counter fails both ends of this sweep, and an 8-bit wrap bug fails at 255. It also sends a stop-bit-done while the FIFO still holds data, and a FIFO that empties without a stop bit. A design that released on either of these would cut off the final character. A restart in the middle of the countdown catches a counter that is not reloaded, which would release early on the next frame. An exhaustive sweep over the interrupt inputs in both modes catches an interrupt that ignores the shifter state.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    // control register bit positions (host-visible encoding)
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_DTR_BIT  = 1;
    localparam int CTRL_WAIT_BIT = 2;
    localparam int CTRL_SRST_BIT = 3;

    typedef enum logic [1:0] {
        DIR_IDLE  = 2'd0,
        DIR_TX    = 2'd1,
        DIR_COUNT = 2'd2
    } dir_state_e;

    typedef struct packed {
        logic auto_en;
        logic pin_dtr;
        logic irq_wait_stop;
    } ctrl_t;

endpackage

// File: rtl/dtc_regs.sv
module dtc_regs
    import dtc_pkg::*;
#(
    parameter int DELAY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic               cfg_sel,
    input  logic [DELAY_W-1:0] cfg_wdata,
    output logic [DELAY_W-1:0] delay_o,
    output ctrl_t              ctrl_o,
    output logic               srst_o
);

    typedef struct packed {
        logic [DELAY_W-1:0] delay;
        ctrl_t              ctrl;
        logic               srst;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d      = q;
        d.srst = 1'b0;
        if (q.srst) begin
            d = '0;
        end else if (cfg_wr) begin
            if (!cfg_sel) begin
                d.delay = cfg_wdata;
            end else begin
                d.ctrl.auto_en       = cfg_wdata[CTRL_EN_BIT];
                d.ctrl.pin_dtr       = cfg_wdata[CTRL_DTR_BIT];
                d.ctrl.irq_wait_stop = cfg_wdata[CTRL_WAIT_BIT];
                d.srst               = cfg_wdata[CTRL_SRST_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign delay_o = q.delay;
    assign ctrl_o  = q.ctrl;
    assign srst_o  = q.srst;

    // R10: soft reset lasts exactly one cycle
    p_srst_self_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.srst |=> !q.srst);

    // R10: configuration cleared after soft reset
    p_srst_clears_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.srst |=> (q.delay == '0 && q.ctrl == '0));

    // R11: a delay write lands in the delay register
    p_delay_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_sel && !q.srst) |=> (q.delay == $past(cfg_wdata)));

endmodule

// File: rtl/dtc_dir_fsm.sv
module dtc_dir_fsm
    import dtc_pkg::*;
#(
    parameter int DELAY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               srst,
    input  logic               auto_en,
    input  logic [DELAY_W-1:0] delay,
    input  logic               shift_busy,
    input  logic               stop_done,
    input  logic               fifo_empty,
    input  logic               baud_tick,
    output logic               dir_o
);

    typedef struct packed {
        dir_state_e         state;
        logic [DELAY_W-1:0] cnt;
        logic               dir;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d = q;
        if (srst || !auto_en) begin
            d.state = DIR_IDLE;
            d.cnt   = '0;
            d.dir   = 1'b0;
        end else begin
            unique case (q.state)
                DIR_IDLE: begin
                    if (shift_busy) begin
                        d.state = DIR_TX;
                        d.dir   = 1'b1;
                    end
                end
                DIR_TX: begin
                    d.dir = 1'b1;
                    if (stop_done && fifo_empty && !shift_busy) begin
                        d.state = DIR_COUNT;
                        d.cnt   = delay;
                    end
                end
                DIR_COUNT: begin
                    if (shift_busy) begin
                        d.state = DIR_TX;
                        d.dir   = 1'b1;
                    end else if (baud_tick) begin
                        if (q.cnt == '0) begin
                            d.state = DIR_IDLE;
                            d.dir   = 1'b0;
                        end else begin
                            d.cnt = q.cnt - 1'b1;
                        end
                    end
                end
                default: begin
                    d.state = DIR_IDLE;
                    d.cnt   = '0;
                    d.dir   = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= DIR_IDLE;
            q.cnt   <= '0;
            q.dir   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign dir_o = q.dir;

    // R3: no countdown without a qualifying stop-bit-done
    p_start_needs_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == DIR_TX && !(stop_done && fifo_empty)) |=> (q.state != DIR_COUNT));

    // R4: pin held while no tick arrives
    p_hold_until_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == DIR_COUNT && !baud_tick && !srst && auto_en) |=> dir_o);

    // R4: each tick removes one bit period
    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == DIR_COUNT && baud_tick && !shift_busy && !srst && auto_en && q.cnt != '0)
        |=> (q.cnt == $past(q.cnt) - 1'b1));

    // R4: exhausted count releases the line on the tick
    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == DIR_COUNT && baud_tick && !shift_busy && q.cnt == '0) |=> !dir_o);

    // R5: new data aborts the countdown
    p_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == DIR_COUNT && shift_busy && !srst && auto_en)
        |=> (q.state == DIR_TX && dir_o));

    // R7: disabled block never drives
    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> !dir_o);

endmodule

// File: rtl/dtc_irq_gen.sv
module dtc_irq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic srst,
    input  logic wait_stop,
    input  logic fifo_empty,
    input  logic fifo_below_trig,
    input  logic shift_busy,
    output logic irq_o
);

    logic irq_d, irq_q;

    always_comb begin
        if (srst) begin
            irq_d = 1'b0;
        end else begin
            irq_d = fifo_below_trig
                  | (fifo_empty & (!wait_stop | !shift_busy));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_o = irq_q;

    // R8: below trigger always raises the interrupt
    p_below_trig_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_below_trig && !srst) |=> irq_o);

    // R9: in wait mode a busy shifter masks the empty condition
    p_wait_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_stop && shift_busy && !fifo_below_trig) |=> !irq_o);

endmodule

// File: rtl/rs485_dir_turnaround.sv
module rs485_dir_turnaround
    import dtc_pkg::*;
#(
    parameter int DELAY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic               cfg_sel,
    input  logic [DELAY_W-1:0] cfg_wdata,
    input  logic               baud_tick,
    input  logic               shift_busy,
    input  logic               stop_done,
    input  logic               fifo_empty,
    input  logic               fifo_below_trig,
    output logic               dir_rts,
    output logic               dir_dtr,
    output logic               tx_empty_irq
);

    logic [DELAY_W-1:0] delay;
    ctrl_t              ctrl;
    logic               srst;
    logic               dir;

    dtc_regs #(.DELAY_W(DELAY_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .delay_o   (delay),
        .ctrl_o    (ctrl),
        .srst_o    (srst)
    );

    dtc_dir_fsm #(.DELAY_W(DELAY_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .srst       (srst),
        .auto_en    (ctrl.auto_en),
        .delay      (delay),
        .shift_busy (shift_busy),
        .stop_done  (stop_done),
        .fifo_empty (fifo_empty),
        .baud_tick  (baud_tick),
        .dir_o      (dir)
    );

    dtc_irq_gen u_irq (
        .clk             (clk),
        .rst_n           (rst_n),
        .srst            (srst),
        .wait_stop       (ctrl.irq_wait_stop),
        .fifo_empty      (fifo_empty),
        .fifo_below_trig (fifo_below_trig),
        .shift_busy      (shift_busy),
        .irq_o           (tx_empty_irq)
    );

    assign dir_rts = dir & !ctrl.pin_dtr;
    assign dir_dtr = dir &  ctrl.pin_dtr;

    // R6: never both pins driving
    p_one_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(dir_rts && dir_dtr));

endmodule

// File: tb/sim_rs485_dir_turnaround.sv
module sim_rs485_dir_turnaround;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       baud_tick = 1'b0;
    logic       shift_busy = 1'b0;
    logic       stop_done = 1'b0;
    logic       fifo_empty = 1'b1;
    logic       fifo_below_trig = 1'b0;
    logic       dir_rts, dir_dtr, tx_empty_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rs485_dir_turnaround u0 (
        .clk (clk), .rst_n (rst_n), .cfg_wr (cfg_wr), .cfg_sel (cfg_sel),
        .cfg_wdata (cfg_wdata), .baud_tick (baud_tick), .shift_busy (shift_busy),
        .stop_done (stop_done), .fifo_empty (fifo_empty),
        .fifo_below_trig (fifo_below_trig), .dir_rts (dir_rts),
        .dir_dtr (dir_dtr), .tx_empty_irq (tx_empty_irq)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic tick();
        baud_tick = 1'b1;
        @(negedge clk);
        baud_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // shifter sends one character then signals its final stop bit
    task automatic frame();
        shift_busy = 1'b1;
        @(negedge clk);
        shift_busy = 1'b0;
        stop_done  = 1'b1;
        @(negedge clk);
        stop_done  = 1'b0;
    endtask

    task automatic run_delay(input int n);
        wr(1'b0, n[7:0]);
        frame();
        for (int k = 1; k <= n + 1; k++) begin
            idle(2);
            tick();
            if (k == n) check("R4 still driving after tick N", dir_rts, 1'b1);
            if (k == n + 1) check("R4 released after tick N+1", dir_rts, 1'b0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(2);
        // R1 reset state
        check("R1 rts", dir_rts, 1'b0);
        check("R1 dtr", dir_dtr, 1'b0);
        check("R1 irq", tx_empty_irq, 1'b0);
        rst_n = 1'b1;
        idle(1);

        // R7 disabled: shifter activity ignored
        shift_busy = 1'b1;
        idle(2);
        check("R7 rts quiet while disabled", dir_rts, 1'b0);
        check("R7 dtr quiet while disabled", dir_dtr, 1'b0);
        shift_busy = 1'b0;

        // R1/R11: default delay 0 after reset, control write enables
        wr(1'b1, 8'h01);
        frame();
        check("R2 pin driving after frame", dir_rts, 1'b1);
        tick();
        check("R1 reset delay releases on first tick", dir_rts, 1'b0);

        // R2 timing: pin rises at the edge sampling shift_busy
        shift_busy = 1'b1;
        @(negedge clk);
        check("R2 rts rises", dir_rts, 1'b1);
        check("R6 dtr idle when rts selected", dir_dtr, 1'b0);
        shift_busy = 1'b0;
        stop_done = 1'b1;
        @(negedge clk);
        stop_done = 1'b0;
        tick();

        // R4 sweep, including 0 and 255
        for (int n = 0; n <= 16; n++) run_delay(n);
        for (int n = 250; n <= 255; n++) run_delay(n);

        // R3: stop with data still queued, then empty without stop
        wr(1'b0, 8'd0);
        fifo_empty = 1'b0;
        frame();
        for (int k = 0; k < 5; k++) begin idle(1); tick(); end
        check("R3 stop with queued data keeps driving", dir_rts, 1'b1);
        fifo_empty = 1'b1;
        for (int k = 0; k < 5; k++) begin idle(1); tick(); end
        check("R3 fifo empty alone keeps driving", dir_rts, 1'b1);
        stop_done = 1'b1;
        @(negedge clk);
        stop_done = 1'b0;
        check("R3 counting after qualifying stop", dir_rts, 1'b1);
        tick();
        check("R3 release after qualified stop", dir_rts, 1'b0);

        // R5: abort mid countdown and reload the full delay
        wr(1'b0, 8'd10);
        frame();
        for (int k = 0; k < 3; k++) begin idle(1); tick(); end
        shift_busy = 1'b1;
        @(negedge clk);
        shift_busy = 1'b0;
        for (int k = 0; k < 20; k++) begin idle(1); tick(); end
        check("R5 aborted countdown holds pin", dir_rts, 1'b1);
        stop_done = 1'b1;
        @(negedge clk);
        stop_done = 1'b0;
        for (int k = 1; k <= 11; k++) begin
            idle(1);
            tick();
            if (k == 10) check("R5 reloaded delay not yet expired", dir_rts, 1'b1);
            if (k == 11) check("R5 release after full reload", dir_rts, 1'b0);
        end

        // R6: select DTR as direction pin
        wr(1'b1, 8'h03);
        wr(1'b0, 8'd1);
        frame();
        check("R6 dtr drives", dir_dtr, 1'b1);
        check("R6 rts idle when dtr selected", dir_rts, 1'b0);
        tick();
        check("R6 dtr held after first tick", dir_dtr, 1'b1);
        tick();
        check("R6 dtr released", dir_dtr, 1'b0);

        // R8/R9: exhaustive interrupt sweep
        for (int m = 0; m < 2; m++) begin
            wr(1'b1, m[0] ? 8'h04 : 8'h00);
            for (int v = 0; v < 8; v++) begin
                fifo_empty      = v[0];
                fifo_below_trig = v[1];
                shift_busy      = v[2];
                @(negedge clk);
                if (m == 0)
                    check("R8 irq mode 0", tx_empty_irq, v[1] | v[0]);
                else
                    check("R9 irq mode 1", tx_empty_irq, v[1] | (v[0] & !v[2]));
            end
        end
        shift_busy = 1'b0; fifo_empty = 1'b1; fifo_below_trig = 1'b0;

        // R10: soft reset while driving
        wr(1'b1, 8'h01);
        wr(1'b0, 8'd5);
        shift_busy = 1'b1;
        @(negedge clk);
        shift_busy = 1'b0;
        check("R10 driving before soft reset", dir_rts, 1'b1);
        wr(1'b1, 8'h09);
        @(negedge clk);
        check("R10 pin low after soft reset", dir_rts, 1'b0);
        shift_busy = 1'b1;
        idle(2);
        shift_busy = 1'b0;
        check("R10 control cleared by soft reset", dir_rts, 1'b0);
        wr(1'b1, 8'h01);
        frame();
        check("R10 reset bit self-cleared, block usable", dir_rts, 1'b1);
        tick();
        check("R10 delay cleared by soft reset", dir_rts, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule